// File: doc/BRIEF.md
# Scan Shift Weighted Transition Counter

This block estimates how much switching a scan chain of fixed length sees while one pattern is shifted through it. Bits of a pattern arrive one per accepted cycle. Each time a bit differs from the bit before it, that transition is added to a running sum with a weight that depends on where the pair sits in the pattern. When shifting a pattern in, a transition near the front of the stream travels through more cells before the load is complete, so it weighs more. When shifting a response out, the weighting runs the other way.

The block is driven by a serial bit with a valid qualifier, a start marker that tags the first bit of each pattern, and a direction select that is sampled together with the first bit. After the last bit of the chain has been accepted, the block publishes the total and raises a one-cycle done strobe. The published total stays on the output until the next pattern finishes.

A small state machine has three states. `ST_IDLE` waits for a start-tagged bit. `ST_GATHER` accepts bits and sums transitions. `ST_REPORT` lasts one cycle and drives the done strobe. The transitions are as follows. Any start-tagged valid bit moves the machine to `ST_GATHER` from every state. `ST_GATHER` moves to `ST_REPORT` on the final bit. `ST_REPORT` returns to `ST_IDLE` unless a new start arrives in that cycle.

Top module: `scan_wtc_counter`

## Requirements
- R1: A transition is counted only between two successive accepted bits of the same pattern that differ. Equal neighbours add nothing, so an all-zero or all-one pattern totals 0.
- R2: With `dir_i` = 0 (shift in), the transition between bit j and bit j+1 (bits numbered from 1 in arrival order) adds CHAIN_LEN − j.
- R3: With `dir_i` = 1 (shift out), the transition between bit j and bit j+1 adds j.
- R4: A valid bit with `bit_sof_i` = 1 is bit 1 of a new pattern. It clears the sum, samples `dir_i` and only sets the previous-bit reference. No transition is counted against the last bit of the previous pattern.
- R5: In the cycle after bit CHAIN_LEN is accepted, `done_o` is high for exactly one cycle and `wtc_o` shows the total. `wtc_o` holds that value until the next completion.
- R6: Cycles with `bit_vld_i` = 0 are ignored, so idle gaps between bits do not change the total.
- R7: A start-tagged bit that arrives mid-pattern abandons the partial sum and begins a new pattern. The new pattern uses its own sampled direction.
- R8: Valid bits without a start tag are ignored while no pattern is being gathered. They raise no done strobe and leave `wtc_o` unchanged.
- R9: The total is exact up to the maximum CHAIN_LEN·(CHAIN_LEN−1)/2, which a fully alternating pattern reaches in either direction.
- R10: While reset is asserted, `done_o` is 0 and `wtc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_vld_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_sof_i | input | 1 | Marks the qualified bit as bit 1 of a pattern |
| bit_i | input | 1 | Serial pattern bit |
| dir_i | input | 1 | 0 = shift in, 1 = shift out; sampled with bit 1 |
| done_o | output | 1 | One-cycle strobe when a total is published |
| wtc_o | output | $clog2(CHAIN_LEN·(CHAIN_LEN−1)/2+1) | Published weighted transition total |

## Verification
The bench uses single transitions placed at the first and last pair of a pattern. A design with the weight direction reversed, or with the index off by one, reports 1 where 7 is due, or the reverse. It sends a pattern of all zeros after one that ended in a one. A design that keeps the previous-bit reference across patterns then shows a spurious transition. It restarts a pattern halfway through in the other direction, which exposes a partial sum that survives or a direction that is not resampled. It sends untagged bits after a completion and spreads bits out with idle gaps. A design that counts such bits fires an extra done strobe, loses its total, or changes its count.

// File: rtl/scan_wtc_pkg.sv
package scan_wtc_pkg;

    typedef enum logic {
        SHIFT_IN  = 1'b0,
        SHIFT_OUT = 1'b1
    } shift_dir_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_REPORT = 2'd2
    } wtc_state_e;

endpackage

// File: rtl/scan_wtc_ctrl.sv
module scan_wtc_ctrl
    import scan_wtc_pkg::*;
#(
    parameter int CHAIN_LEN = 32,
    parameter int POS_W     = $clog2(CHAIN_LEN + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vld_i,
    input  logic             sof_i,
    input  logic             bit_i,
    input  shift_dir_e       dir_i,
    output logic             clear_o,
    output logic             add_o,
    output logic             commit_o,
    output logic             report_o,
    output logic [POS_W-1:0] hop_o,
    output shift_dir_e       dir_o
);

    localparam logic [POS_W-1:0] LAST_HOP = POS_W'(CHAIN_LEN - 1);

    wtc_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q;
    logic             prev_q;
    shift_dir_e       dir_q;

    logic take_first;
    logic take_next;
    logic final_bit;

    assign take_first = vld_i && sof_i;
    assign take_next  = vld_i && !sof_i && (state_q == ST_GATHER);
    assign final_bit  = take_next && (pos_q == LAST_HOP);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_first) state_d = ST_GATHER;
            end
            ST_GATHER: begin
                if (take_first)     state_d = ST_GATHER;
                else if (final_bit) state_d = ST_REPORT;
            end
            ST_REPORT: begin
                state_d = take_first ? ST_GATHER : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // bit position, previous bit and direction tracking
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q  <= '0;
            prev_q <= 1'b0;
            dir_q  <= SHIFT_IN;
        end else if (take_first) begin
            pos_q  <= POS_W'(1);
            prev_q <= bit_i;
            dir_q  <= dir_i;
        end else if (take_next) begin
            pos_q  <= pos_q + POS_W'(1);
            prev_q <= bit_i;
        end
    end

    // outputs
    always_comb begin
        clear_o  = take_first;
        add_o    = take_next && (bit_i != prev_q);
        commit_o = final_bit;
        report_o = (state_q == ST_REPORT);
        hop_o    = pos_q;
        dir_o    = dir_q;
    end

    assert_pos_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_q <= POS_W'(CHAIN_LEN));

    assert_start_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && sof_i) |=> (pos_q == POS_W'(1) && state_q == ST_GATHER));

    assert_untagged_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && !sof_i && state_q != ST_GATHER) |=> (state_q != ST_GATHER && $stable(pos_q)));

    assert_gap_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vld_i) |=> $stable(pos_q));

endmodule

// File: rtl/scan_wtc_weight.sv
module scan_wtc_weight
    import scan_wtc_pkg::*;
#(
    parameter int CHAIN_LEN = 32,
    parameter int POS_W     = $clog2(CHAIN_LEN + 1)
) (
    input  logic [POS_W-1:0] hop_i,
    input  shift_dir_e       dir_i,
    output logic [POS_W-1:0] weight_o
);

    localparam logic [POS_W-1:0] LEN_V = POS_W'(CHAIN_LEN);

    // hop_i is j: the transition lies between bit j and bit j+1
    always_comb begin
        unique case (dir_i)
            SHIFT_OUT: weight_o = hop_i;
            default:   weight_o = LEN_V - hop_i;
        endcase
    end

endmodule

// File: rtl/scan_wtc_accum.sv
module scan_wtc_accum #(
    parameter int CHAIN_LEN = 32,
    parameter int POS_W     = $clog2(CHAIN_LEN + 1),
    parameter int ACC_W     = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             add_i,
    input  logic             commit_i,
    input  logic [POS_W-1:0] weight_i,
    output logic [ACC_W-1:0] result_o
);

    localparam int ACC_MAX = CHAIN_LEN * (CHAIN_LEN - 1) / 2;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] sum;

    assign inc = add_i ? ACC_W'(weight_i) : '0;
    assign sum = acc_q + inc;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (add_i) begin
            acc_q <= sum;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_o <= '0;
        end else if (commit_i) begin
            result_o <= sum;
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_q <= ACC_W'(ACC_MAX));

    assert_weight_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        add_i |-> (weight_i >= POS_W'(1) && weight_i <= POS_W'(CHAIN_LEN - 1)));

    assert_result_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!commit_i) |=> $stable(result_o));

    assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (acc_q == '0));

endmodule

// File: rtl/scan_wtc_counter.sv
module scan_wtc_counter
    import scan_wtc_pkg::*;
#(
    parameter  int CHAIN_LEN = 32,
    localparam int ACC_W     = $clog2(CHAIN_LEN * (CHAIN_LEN - 1) / 2 + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bit_vld_i,
    input  logic             bit_sof_i,
    input  logic             bit_i,
    input  logic             dir_i,
    output logic             done_o,
    output logic [ACC_W-1:0] wtc_o
);

    localparam int POS_W = $clog2(CHAIN_LEN + 1);

    logic             clear;
    logic             add;
    logic             commit;
    logic             report;
    logic [POS_W-1:0] hop;
    logic [POS_W-1:0] weight;
    shift_dir_e       dir_q;

    scan_wtc_ctrl #(
        .CHAIN_LEN (CHAIN_LEN),
        .POS_W     (POS_W)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .vld_i    (bit_vld_i),
        .sof_i    (bit_sof_i),
        .bit_i    (bit_i),
        .dir_i    (shift_dir_e'(dir_i)),
        .clear_o  (clear),
        .add_o    (add),
        .commit_o (commit),
        .report_o (report),
        .hop_o    (hop),
        .dir_o    (dir_q)
    );

    scan_wtc_weight #(
        .CHAIN_LEN (CHAIN_LEN),
        .POS_W     (POS_W)
    ) u_weight (
        .hop_i    (hop),
        .dir_i    (dir_q),
        .weight_o (weight)
    );

    scan_wtc_accum #(
        .CHAIN_LEN (CHAIN_LEN),
        .POS_W     (POS_W),
        .ACC_W     (ACC_W)
    ) u_accum (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (clear),
        .add_i    (add),
        .commit_i (commit),
        .weight_i (weight),
        .result_o (wtc_o)
    );

    assign done_o = report;

    assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_total_moves_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!done_o) |-> $stable(wtc_o));

    assert_total_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wtc_o <= ACC_W'(CHAIN_LEN * (CHAIN_LEN - 1) / 2));

endmodule

// File: tb/scan_wtc_counter_tb_top.sv
module scan_wtc_counter_tb_top;

    localparam int M  = 8;
    localparam int AW = $clog2(M * (M - 1) / 2 + 1);

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld   = 1'b0;
    logic          sof   = 1'b0;
    logic          sbit  = 1'b0;
    logic          dir   = 1'b0;
    logic          done;
    logic [AW-1:0] wtc;

    always #10 clk = ~clk;

    scan_wtc_counter #(.CHAIN_LEN(M)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .bit_vld_i (vld),
        .bit_sof_i (sof),
        .bit_i     (sbit),
        .dir_i     (dir),
        .done_o    (done),
        .wtc_o     (wtc)
    );

    int n_cmp  = 0;
    int n_bad  = 0;
    bit wd_hit = 1'b0;

    // behavioural reference, evaluated on every clock
    int r_active = 0;
    int r_pos    = 0;
    int r_prev   = 0;
    int r_dir    = 0;
    int r_acc    = 0;
    int r_wtc    = 0;
    int r_done   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            r_active = 0; r_pos = 0; r_acc = 0; r_wtc = 0; r_done = 0;
        end else begin
            r_done = 0;
            if (vld) begin
                if (sof) begin
                    r_active = 1; r_pos = 1; r_prev = int'(sbit); r_dir = int'(dir); r_acc = 0;
                end else if (r_active != 0) begin
                    r_pos++;
                    if (int'(sbit) != r_prev)
                        r_acc += (r_dir != 0) ? (r_pos - 1) : (M - r_pos + 1);
                    r_prev = int'(sbit);
                    if (r_pos == M) begin
                        r_wtc = r_acc; r_done = 1; r_active = 0;
                    end
                end
            end
        end
    end

    function automatic string cyc_tag(input int d);
        return (d != 0) ? "R3/R5" : "R2/R5";
    endfunction

    always @(negedge clk) begin
        if (rst_n && !wd_hit) begin
            n_cmp++;
            if (done !== r_done[0] || wtc !== AW'(r_wtc)) begin
                n_bad++;
                $display("FAIL %s per-cycle: done=%0b wtc=%0d expected done=%0b wtc=%0d",
                         cyc_tag(r_dir), done, wtc, r_done[0], r_wtc);
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic put(input logic b, input logic s, input logic d);
        vld = 1'b1; sbit = b; sof = s; dir = d;
        @(posedge clk); #1;
    endtask

    task automatic rest(input int n);
        vld = 1'b0; sof = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // v[0] is bit 1 (first to arrive)
    task automatic send_vec(input logic [M-1:0] v, input logic d, input int gap);
        for (int k = 0; k < M; k++) begin
            put(v[k], (k == 0), d);
            if (gap > 0 && k < M - 1) rest(gap);
        end
    endtask

    task automatic vec_check(input string req, input logic [M-1:0] v, input logic d,
                             input int gap, input int exp);
        send_vec(v, d, gap);
        chk({req, " done strobe"}, int'(done), 1);
        chk(req, int'(wtc), exp);
        rest(1);
        chk("R5 strobe drops", int'(done), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL R5 watchdog: got no end expected end of run");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset wtc", int'(wtc), 0);
        rst_n = 1'b1;
        rest(2);

        // R9: alternating pattern reaches the maximum both ways
        vec_check("R9 R2 alternating shift-in", 8'hAA, 1'b0, 0, 28);
        vec_check("R9 R3 alternating shift-out", 8'hAA, 1'b1, 0, 28);

        // single transition at the last pair (j = 7)
        vec_check("R2 last pair shift-in", 8'h80, 1'b0, 0, 1);
        vec_check("R3 last pair shift-out", 8'h80, 1'b1, 0, 7);

        // single transition at the first pair (j = 1)
        vec_check("R2 first pair shift-in", 8'h01, 1'b0, 0, 7);
        vec_check("R3 first pair shift-out", 8'h01, 1'b1, 0, 1);

        // R4: previous pattern ends with 1, new all-zero pattern must total 0
        vec_check("R2 setup ending in one", 8'h80, 1'b0, 0, 1);
        vec_check("R4 no carry across patterns", 8'h00, 1'b0, 0, 0);
        vec_check("R1 all ones", 8'hFF, 1'b1, 0, 0);

        // R6: gaps between bits (transition at j = 2)
        vec_check("R2 back-to-back j=2", 8'h03, 1'b0, 0, 6);
        vec_check("R6 gapped shift-in", 8'h03, 1'b0, 3, 6);
        vec_check("R6 gapped shift-out", 8'h03, 1'b1, 2, 2);

        // R7: partial shift-out pattern abandoned by a new shift-in start
        put(1'b0, 1'b1, 1'b1);
        put(1'b1, 1'b0, 1'b1);
        put(1'b0, 1'b0, 1'b1);
        put(1'b1, 1'b0, 1'b1);
        vec_check("R7 restart mid-pattern", 8'h80, 1'b0, 0, 1);

        // R8: untagged bits while idle are ignored
        for (int k = 0; k < 12; k++) begin
            put(k[0], 1'b0, 1'b0);
            chk("R8 no strobe on untagged bits", int'(done), 0);
            chk("R8 total held", int'(wtc), 1);
        end
        rest(2);
        vec_check("R1 R2 after ignored bits", 8'h0F, 1'b0, 1, 4);

        rest(3);
        summary();
        $finish;
    end

endmodule